// File: doc/BRIEF.md
# Configurable SPI serial transfer engine

This block moves one serial word at a time over a three-wire SPI link. It can be the bus master, which generates the serial clock and starts each word, or the slave, which follows a clock and a select line driven from outside. A set of static configuration inputs chooses the role, the clock idle level (CPOL), the clock phase (CPHA), an 8-bit baud divisor, a 4-bit word-length code and an open-drain signalling option. A one-cycle command strobe supplies the transmit word and a flag that, in master mode, decides whether the length code applies.

In master mode the command starts a transfer at once. The engine then produces SCK from the system clock, shifts the transmit word out most significant bit first on MOSI, and gathers MISO into a receive word. In slave mode the command only loads the word to send. The transfer itself is framed by the external select going low, and SCK, MOSI and select are passed through synchronizers first. In both roles a single-cycle done pulse marks the end of each word. The received word is right-aligned and stays on its output until the next word completes.

Top module: `spi_xfer_engine`

## Requirements
- R1: A master transfer starts only on `cmd_valid` with `cfg_master`=1, no master transfer in progress and `cfg_div` >= 2. Otherwise SCK never changes and no done pulse is produced. In slave mode `sck_oe` is 0.
- R2: Length code: 4'b0000 gives 16 bits. Codes 4'b1000 through 4'b1111 give a length equal to the code value (8 to 15). Codes 4'b0001 through 4'b0111 give 8 bits.
- R3: In master mode, when `cmd_len_en` is 0, exactly 8 bits are transferred whatever `cfg_len_code` holds. When it is 1, the R2 length is used.
- R4: In slave mode, the R2 length always applies and `cmd_len_en` has no effect. Exactly one done pulse follows that many sampling edges while the select (`ss_n_in`, active low) is held low.
- R5: While idle, SCK rests at `cfg_cpol`. In a master transfer of N bits, SCK makes 2N transitions. The first comes `cfg_div` system clocks after the clock edge that accepts the command, and each later one `cfg_div` clocks after the previous one.
- R6: With CPHA=0, data is sampled on the leading (away-from-idle) SCK edge and changed on the trailing edge, and the first MOSI bit is valid before the first edge. With CPHA=1, data is changed on the leading edge and sampled on the trailing edge. Bits go MSB first: bit N-1 of `cmd_data` is sent first.
- R7: The received word holds the N received bits in `rx_data[N-1:0]`, with the first received bit as bit N-1, and all upper bits 0.
- R8: In master mode, `rx_done` is high for exactly one system clock, starting at the clock edge that makes the last SCK transition. `rx_data` changes only in a cycle where `rx_done` is 1.
- R9: Each driven pin (SCK, MOSI, MISO) has a value/enable pair. With `cfg_odrain`=0, out = value and oe = drive enable. With `cfg_odrain`=1, out is always 0 and oe is 1 only for a driven 0, so a 1 comes from an external pull-up. This holds whether or not a transfer is running.
- R10: In slave mode, MISO is driven (`miso_oe`=1 when the pin is not released by open-drain) only while the select is low. The word sent is the `cmd_data` of the last command received in slave mode, MSB first at the R2 length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 = master role, 0 = slave role |
| cfg_odrain | input | 1 | 1 = open-drain style output signalling |
| cfg_len_code | input | 4 | Word-length code |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | SCK phase select |
| cfg_div | input | 8 | Baud divisor, half SCK period in system clocks |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_len_en | input | 1 | Apply length code (master only) |
| cmd_data | input | 16 | Transmit word, right-aligned |
| sck_in | input | 1 | SCK from external master (slave role) |
| mosi_in | input | 1 | MOSI from external master (slave role) |
| ss_n_in | input | 1 | Active-low select (slave role) |
| miso_in | input | 1 | MISO from external slave (master role) |
| sck_out | output | 1 | SCK pin value |
| sck_oe | output | 1 | SCK pin output enable |
| mosi_out | output | 1 | MOSI pin value |
| mosi_oe | output | 1 | MOSI pin output enable |
| miso_out | output | 1 | MISO pin value |
| miso_oe | output | 1 | MISO pin output enable |
| rx_done | output | 1 | One-cycle word-complete pulse |
| rx_data | output | 16 | Received word, right-aligned |

## Verification
The hardest case to reach from the ports is a slave word with CPHA=1. There the first leading edge must not shift the transmit word, and the edge is seen only after the synchronizer delay. It also has to be run together with a reserved length code and a cleared length flag, which the slave must ignore. The bench acts as the external master itself. It holds the select low, sets MOSI and then toggles SCK ten system clocks apart in both phase orders, capturing MISO at its own sampling points. Master transfers are checked by a bench-side slave model that reacts to each resolved SCK transition. It measures the spacing of the edges, picks MOSI up at the sampling edges and feeds MISO at the change edges, over random codes, flags, divisors and pin modes.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  localparam int WORD_W = 16;
  localparam int LEN_W  = $clog2(WORD_W + 1);
  localparam int CODE_W = 4;

  typedef logic [LEN_W-1:0]  len_t;
  typedef logic [WORD_W-1:0] word_t;

  // Length code to bit count: zero selects a full word, the upper half maps to itself.
  function automatic len_t code_to_len(input logic [CODE_W-1:0] code);
    if (code == '0)
      return len_t'(WORD_W);
    else if (code[CODE_W-1])
      return len_t'(code);
    else
      return len_t'(8);
  endfunction

  // Effective length: a master with the flag cleared always moves a byte.
  function automatic len_t xfer_len(input logic [CODE_W-1:0] code,
                                    input logic is_master,
                                    input logic len_en);
    if (is_master && !len_en)
      return len_t'(8);
    return code_to_len(code);
  endfunction

  // Move the low n bits of a word to the top so bit WORD_W-1 leaves first.
  function automatic word_t left_align(input word_t d, input len_t n);
    return d << (len_t'(WORD_W) - n);
  endfunction
endpackage

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (!run || tick)
      cnt <= '0;
    else
      cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++)
        pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++)
        pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_pin_drive.sv
module spi_pin_drive #(
  parameter int N = 3
) (
  input  logic [N-1:0] val,
  input  logic [N-1:0] en,
  input  logic         od,
  output logic [N-1:0] out,
  output logic [N-1:0] oe
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    assign out[g] = od ? 1'b0 : val[g];
    assign oe[g]  = en[g] & (~od | ~val[g]);
  end
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_xfer_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_master,
  input  logic              cfg_odrain,
  input  logic [CODE_W-1:0] cfg_len_code,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cmd_valid,
  input  logic              cmd_len_en,
  input  logic [WORD_W-1:0] cmd_data,
  input  logic              sck_in,
  input  logic              mosi_in,
  input  logic              ss_n_in,
  input  logic              miso_in,
  output logic              sck_out,
  output logic              sck_oe,
  output logic              mosi_out,
  output logic              mosi_oe,
  output logic              miso_out,
  output logic              miso_oe,
  output logic              rx_done,
  output logic [WORD_W-1:0] rx_data
);
  localparam int H_W = LEN_W + 1;

  function automatic logic div_ok(input logic [DIV_W-1:0] d);
    return d >= DIV_W'(2);
  endfunction

  // ---------------- master side ----------------
  logic             m_busy, m_tgl, m_cpol, m_cpha;
  logic [H_W-1:0]   m_h;
  len_t             m_len;
  logic [DIV_W-1:0] m_div;
  word_t            m_tx, m_rx, m_rx_nxt, m_word;
  logic             m_tick, m_start, m_lead, m_samp, m_shift, m_last, m_fin;
  len_t             m_len_new;

  assign m_start   = cfg_master & cmd_valid & ~m_busy & div_ok(cfg_div);
  assign m_len_new = xfer_len(cfg_len_code, 1'b1, cmd_len_en);
  assign m_lead    = ~m_h[0];
  assign m_samp    = m_lead ^ m_cpha;
  assign m_shift   = ~m_samp & ~(m_cpha & (m_h == '0));
  assign m_last    = (m_h == (({1'b0, m_len} << 1) - H_W'(1)));
  assign m_fin     = m_busy & m_tick & m_last;
  assign m_rx_nxt  = {m_rx[WORD_W-2:0], miso_in};
  assign m_word    = m_samp ? m_rx_nxt : m_rx;

  spi_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (m_busy),
    .div  (m_div),
    .tick (m_tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0;
      m_tgl  <= 1'b0;
      m_cpol <= 1'b0;
      m_cpha <= 1'b0;
      m_h    <= '0;
      m_len  <= len_t'(8);
      m_div  <= '0;
      m_tx   <= '0;
      m_rx   <= '0;
    end else if (m_start) begin
      m_busy <= 1'b1;
      m_tgl  <= 1'b0;
      m_cpol <= cfg_cpol;
      m_cpha <= cfg_cpha;
      m_h    <= '0;
      m_len  <= m_len_new;
      m_div  <= cfg_div;
      m_tx   <= left_align(cmd_data, m_len_new);
      m_rx   <= '0;
    end else if (m_busy && m_tick) begin
      m_tgl <= ~m_tgl;
      m_h   <= m_h + H_W'(1);
      if (m_samp)  m_rx <= m_rx_nxt;
      if (m_shift) m_tx <= m_tx << 1;
      if (m_last)  m_busy <= 1'b0;
    end
  end

  logic sck_lvl;
  assign sck_lvl = m_busy ? (m_cpol ^ m_tgl) : cfg_cpol;

  // ---------------- slave side ----------------
  logic [2:0] s_sync_q;
  logic       s_ss_n, s_sck, s_mosi, s_sck_d, s_sel_d, s_sel;
  logic       s_act, s_first, s_edge, s_lead, s_samp, s_start, s_lastbit, s_fin;
  len_t       s_cnt, s_len;
  word_t      s_buf, s_tx, s_rx, s_rx_nxt;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({ss_n_in, sck_in, mosi_in}),
    .q    (s_sync_q)
  );

  assign {s_ss_n, s_sck, s_mosi} = s_sync_q;
  assign s_sel     = ~s_ss_n;
  assign s_len     = xfer_len(cfg_len_code, 1'b0, 1'b0);
  assign s_edge    = s_sck ^ s_sck_d;
  assign s_lead    = s_sck ^ cfg_cpol;
  assign s_samp    = s_lead ^ cfg_cpha;
  assign s_start   = s_sel & ~s_sel_d & ~cfg_master;
  assign s_lastbit = (s_cnt == s_len - len_t'(1));
  assign s_rx_nxt  = {s_rx[WORD_W-2:0], s_mosi};
  assign s_fin     = s_act & s_sel & ~cfg_master & s_edge & s_samp & s_lastbit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_sck_d <= 1'b0;
      s_sel_d <= 1'b0;
      s_act   <= 1'b0;
      s_first <= 1'b0;
      s_cnt   <= '0;
      s_buf   <= '0;
      s_tx    <= '0;
      s_rx    <= '0;
    end else begin
      s_sck_d <= s_sck;
      s_sel_d <= s_sel;
      if (cmd_valid && !cfg_master)
        s_buf <= cmd_data;
      if (!s_sel || cfg_master) begin
        s_act <= 1'b0;
      end else if (s_start) begin
        s_act   <= 1'b1;
        s_first <= 1'b1;
        s_cnt   <= '0;
        s_rx    <= '0;
        s_tx    <= left_align(s_buf, s_len);
      end else if (s_act && s_edge) begin
        s_first <= 1'b0;
        if (s_samp) begin
          s_rx  <= s_rx_nxt;
          s_cnt <= s_cnt + len_t'(1);
          if (s_lastbit) s_act <= 1'b0;
        end else if (!(cfg_cpha && s_first)) begin
          s_tx <= s_tx << 1;
        end
      end
    end
  end

  // ---------------- result ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_done <= 1'b0;
      rx_data <= '0;
    end else begin
      rx_done <= m_fin | s_fin;
      if (m_fin)      rx_data <= m_word;
      else if (s_fin) rx_data <= s_rx_nxt;
    end
  end

  len_t word_len;
  assign word_len = cfg_master ? m_len : s_len;

  // ---------------- pins: {miso, mosi, sck} ----------------
  logic [2:0] pin_val, pin_en, pin_out, pin_oe;
  assign pin_val = {s_tx[WORD_W-1], m_tx[WORD_W-1], sck_lvl};
  assign pin_en  = {~cfg_master & s_sel, cfg_master, cfg_master};

  spi_pin_drive #(.N(3)) u_pins (
    .val(pin_val),
    .en (pin_en),
    .od (cfg_odrain),
    .out(pin_out),
    .oe (pin_oe)
  );

  assign {miso_out, mosi_out, sck_out} = pin_out;
  assign {miso_oe,  mosi_oe,  sck_oe}  = pin_oe;
endmodule

// File: rtl/spi_xfer_chk.sv
module spi_xfer_chk
  import spi_xfer_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             m_busy,
  input logic             m_tick,
  input logic             sck_lvl,
  input logic             cfg_master,
  input logic             cfg_odrain,
  input logic [DIV_W-1:0] cfg_div,
  input logic             rx_done,
  input word_t            rx_data,
  input len_t             word_len,
  input logic             sck_out,
  input logic             mosi_out,
  input logic             miso_out
);
  // R1: no master transfer may begin in slave role or with an illegal divisor
  a_r1_no_bad_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!m_busy && (!cfg_master || cfg_div < DIV_W'(2))) |=> !m_busy);

  // R5: SCK moves only on a baud tick while a transfer runs
  a_r5_sck_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (m_busy && !m_tick) |=> $stable(sck_lvl));

  // R8: done lasts one cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  // R8: the received word only moves together with done
  a_r8_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_done |-> $stable(rx_data));

  // R7: bits above the word length are clear
  a_r7_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> ((rx_data >> word_len) == '0));

  // R9: open-drain pins never drive high
  a_r9_od_low: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_odrain |-> (!sck_out && !mosi_out && !miso_out));
endmodule

bind spi_xfer_engine spi_xfer_chk #(.DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .m_busy    (m_busy),
  .m_tick    (m_tick),
  .sck_lvl   (sck_lvl),
  .cfg_master(cfg_master),
  .cfg_odrain(cfg_odrain),
  .cfg_div   (cfg_div),
  .rx_done   (rx_done),
  .rx_data   (rx_data),
  .word_len  (word_len),
  .sck_out   (sck_out),
  .mosi_out  (mosi_out),
  .miso_out  (miso_out)
);

// File: tb/test_spi_xfer_engine.sv
`timescale 1ns/1ps
module test_spi_xfer_engine;
  logic        clk = 0, rst_n = 0;
  logic        cfg_master = 1, cfg_odrain = 0, cfg_cpol = 0, cfg_cpha = 0;
  logic [3:0]  cfg_len_code = 0;
  logic [7:0]  cfg_div = 2;
  logic        cmd_valid = 0, cmd_len_en = 0;
  logic [15:0] cmd_data = 0;
  logic        sck_in = 0, mosi_in = 0, ss_n_in = 1, miso_in = 0;
  logic        sck_out, sck_oe, mosi_out, mosi_oe, miso_out, miso_oe, rx_done;
  logic [15:0] rx_data;

  always #10 clk = ~clk;

  spi_xfer_engine i_spi_xfer_engine (.*);

  wire sck_res  = sck_oe  ? sck_out  : 1'b1;
  wire mosi_res = mosi_oe ? mosi_out : 1'b1;
  wire miso_res = miso_oe ? miso_out : 1'b1;

  int vec = 0, bad = 0, tog = 0, dn_cnt = 0;
  logic [15:0] last_rx = 0;
  localparam int H = 10;

  always @(sck_res) tog++;
  always @(negedge clk) if (rx_done) begin dn_cnt++; last_rx = rx_data; end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [3:0] c, input bit mst, input bit en);
    if (mst && !en) return 8;
    case (c) inside
      4'd0:          return 16;
      [4'd8:4'd15]:  return int'(c);
      default:       return 8;
    endcase
  endfunction

  function automatic logic [15:0] keep(input logic [15:0] d, input int n);
    logic [31:0] m;
    m = (32'h1 << n) - 32'h1;
    return d & m[15:0];
  endfunction

  task automatic run_master(input logic [3:0] code, input bit en, input bit cpol, input bit cpha,
                            input logic [7:0] div, input logic [15:0] txm, input logic [15:0] txs,
                            input bit od);
    int n, b;
    time t_cmd, t_prev;
    bit per_ok;
    logic [15:0] got, hold;
    @(negedge clk);
    cfg_master = 1; cfg_odrain = od; cfg_len_code = code;
    cfg_cpol = cpol; cfg_cpha = cpha; cfg_div = div;
    n = exp_len(code, 1, en);
    repeat (3) @(negedge clk);
    chk(sck_res == cpol, "R5 idle level", sck_res, cpol);
    b = n - 1;
    miso_in = txs[b];
    cmd_valid = 1; cmd_len_en = en; cmd_data = txm;
    t_cmd = $time + 10;
    @(negedge clk);
    cmd_valid = 0;
    per_ok = 1; t_prev = t_cmd; got = 0;
    for (int i = 0; i < 2 * n; i++) begin
      bit lead, samp;
      @(sck_res);
      if ($time - t_prev != time'(int'(div) * 20)) per_ok = 0;
      t_prev = $time;
      #1;
      lead = (i % 2 == 0);
      samp = cpha ? !lead : lead;
      if (samp) got = {got[14:0], mosi_res};
      else if (!(cpha && i == 0)) begin
        b--;
        if (b >= 0) miso_in = txs[b];
      end
    end
    chk(rx_done == 1'b1, en ? "R2 done at edge 2N" : "R3 done at edge 16", rx_done, 1);
    chk(rx_data == keep(txs, n), "R7 master rx word", rx_data, keep(txs, n));
    chk(got == keep(txm, n), "R6 mosi bits", got, keep(txm, n));
    chk(per_ok, "R5 edge spacing", per_ok, 1);
    hold = rx_data;
    @(posedge clk); #1;
    chk(rx_done == 1'b0, "R8 done one cycle", rx_done, 0);
    repeat (4) @(negedge clk);
    chk(rx_data == hold && sck_res == cpol, "R8 rx held, sck idle", rx_data, hold);
  endtask

  task automatic run_slave(input logic [3:0] code, input bit en, input bit cpol, input bit cpha,
                           input logic [15:0] txm, input logic [15:0] txs);
    int n, d0;
    logic [15:0] got;
    @(negedge clk);
    cfg_master = 0; cfg_odrain = 0; cfg_len_code = code; cfg_cpol = cpol; cfg_cpha = cpha;
    cmd_valid = 1; cmd_len_en = en; cmd_data = txs;
    @(negedge clk);
    cmd_valid = 0;
    sck_in = cpol; ss_n_in = 1;
    n = exp_len(code, 0, en);
    repeat (6) @(negedge clk);
    chk(miso_oe == 1'b0, "R10 miso released when deselected", miso_oe, 0);
    chk(sck_oe == 1'b0, "R1 slave leaves sck undriven", sck_oe, 0);
    d0 = dn_cnt; got = 0;
    mosi_in = txm[n-1];
    ss_n_in = 0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      if (!cpha) begin
        mosi_in = txm[n-1-i];
        repeat (H) @(negedge clk);
        got = {got[14:0], miso_res};
        sck_in = ~cpol;
        repeat (H) @(negedge clk);
        sck_in = cpol;
      end else begin
        sck_in = ~cpol;
        mosi_in = txm[n-1-i];
        repeat (H) @(negedge clk);
        got = {got[14:0], miso_res};
        sck_in = cpol;
        repeat (H) @(negedge clk);
      end
    end
    repeat (H) @(negedge clk);
    chk(dn_cnt == d0 + 1, "R4 one done per slave word", dn_cnt - d0, 1);
    chk(last_rx == keep(txm, n), "R7 slave rx word", last_rx, keep(txm, n));
    chk(got == keep(txs, n), "R10 slave miso bits", got, keep(txs, n));
    ss_n_in = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic no_start(input logic [7:0] div, input bit mst);
    int t0, d0;
    @(negedge clk);
    cfg_master = mst; cfg_div = div; cfg_cpol = 0; cfg_odrain = 0;
    repeat (3) @(negedge clk);
    t0 = tog; d0 = dn_cnt;
    cmd_valid = 1; cmd_len_en = 1; cmd_data = 16'hA5A5;
    @(negedge clk);
    cmd_valid = 0;
    repeat (40) @(negedge clk);
    chk(tog == t0 && dn_cnt == d0, "R1 no transfer started", tog - t0, 0);
  endtask

  initial begin
    int seed, dummy;
    seed = 32'h5eed;
    dummy = $urandom(seed);
    repeat (3) @(negedge clk);
    chk(rx_done == 0 && rx_data == 0, "R8 reset state", rx_data, 0);
    chk(sck_res == 0 && sck_oe == 1, "R5 reset idle sck", sck_res, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // directed corners
    run_master(4'b0000, 1, 0, 0, 8'd2, 16'hBEEF, 16'h1234, 0);   // 16 bits (R2)
    run_master(4'b0011, 1, 1, 1, 8'd3, 16'h00C3, 16'h005A, 0);   // reserved -> 8 (R2)
    run_master(4'b1111, 0, 0, 1, 8'd2, 16'h7F81, 16'h6E2D, 0);   // flag clear -> 8 (R3)
    run_master(4'b1001, 1, 1, 0, 8'd4, 16'h0155, 16'h01AA, 1);   // 9 bits, open-drain (R9)

    no_start(8'd1, 1);
    no_start(8'd0, 1);
    no_start(8'd3, 0);

    // R9 pin mapping at idle
    @(negedge clk);
    cfg_master = 1; cfg_odrain = 1; cfg_cpol = 1;
    repeat (2) @(negedge clk);
    chk(sck_out == 0 && sck_oe == 0, "R9 od released high", {sck_out, sck_oe}, 0);
    cfg_cpol = 0;
    repeat (2) @(negedge clk);
    chk(sck_out == 0 && sck_oe == 1, "R9 od driven low", {sck_out, sck_oe}, 1);
    cfg_odrain = 0; cfg_cpol = 1;
    repeat (2) @(negedge clk);
    chk(sck_out == 1 && sck_oe == 1, "R9 push-pull high", {sck_out, sck_oe}, 3);

    for (int k = 0; k < 12; k++)
      run_master(4'($urandom % 16), 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2),
                 8'(2 + $urandom % 3), 16'($urandom), 16'($urandom), 1'($urandom % 2));

    run_slave(4'b0000, 1, 0, 0, 16'hC001, 16'h9AB7);
    run_slave(4'b1010, 1, 1, 1, 16'h02F5, 16'h0316);
    run_slave(4'b1100, 0, 0, 1, 16'h0ABC, 16'h0DEF);   // R4 flag ignored in slave
    run_slave(4'b0101, 0, 1, 0, 16'h00E7, 16'h0018);
    for (int k = 0; k < 6; k++)
      run_slave(4'($urandom % 16), 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2),
                16'($urandom), 16'($urandom));

    summary();
    $finish;
  end
endmodule